// File: doc/BRIEF.md
# Bridge Configuration Cycle Translator

This block is the decision stage of a bridge that receives configuration requests from an upstream link. Each request carries a bus number, a device number, a function number and a register number. It also carries a flag that marks a native special cycle, a compatibility flag and a read/write flag. The block compares the bus number against the bridge's secondary bus number and then picks one of four outcomes.

The first outcome is a type-0 configuration cycle on the secondary bus, addressed through a one-hot IDSEL line. The second is a special cycle on the secondary bus. The third passes the request onward unclaimed. The fourth ends the request with a master abort. A request that carries the compatibility flag is never claimed, and neither is a special cycle that arrives natively on the link. Such a request goes onward, or it is master-aborted when the bridge sits at the end of the chain.

The result is registered. It appears one cycle after the request, together with a single-cycle valid pulse and the secondary-bus address. The address holds the IDSEL line, the function number and the register number. The downstream bus sequencer uses this to drive the real cycle.

Top module: `cfgx_translator`

## Requirements
- R1: For a configuration request (`req_special`=0, `req_compat`=0) whose bus equals `sec_bus_num` and whose device n is in 0..15, `out_kind` is 0 (type-0 cycle) and `out_addr` bit 16+n is the only bit set in `out_addr[31:16]`.
- R2: For a type-0 cycle, `out_addr[10:8]` holds the function number and `out_addr[7:2]` holds the register number. `out_addr[15:11]` and `out_addr[1:0]` are zero.
- R3: A configuration request to device 31 on the secondary bus gives `out_kind` 1 (special cycle) with `out_addr` all zero.
- R4: A configuration request to a device in 16..30 on the secondary bus gives `out_kind` 3 (master abort). `out_ones` is 1 for a read (`req_write`=0) and 0 for a write.
- R5: A request with `req_compat`=1 is never claimed, whatever its bus and device. It gives `out_kind` 2 (pass onward) when `chain_end`=0 and `out_kind` 3 when `chain_end`=1.
- R6: A native special cycle (`req_special`=1) is never claimed. It gives `out_kind` 2 when `chain_end`=0 and 3 when `chain_end`=1.
- R7: A configuration request whose bus differs from `sec_bus_num` gives `out_kind` 2 when `chain_end`=0 and 3 when `chain_end`=1.
- R8: `out_valid` is high in exactly the cycle after each cycle with `req_valid` high. `out_kind`, `out_addr` and `out_ones` hold their values while no request arrives.
- R9: While reset is asserted, `out_valid`, `out_kind`, `out_addr` and `out_ones` are all zero.
- R10: `out_ones` is 1 only with a master abort of a read. For every unclaimed outcome, `out_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_bus_num | input | 8 | Secondary bus number of the bridge |
| chain_end | input | 1 | Bridge is the last device on the link chain |
| req_valid | input | 1 | Request present this cycle |
| req_special | input | 1 | Request is a native special cycle from the link |
| req_compat | input | 1 | Compatibility flag of the request |
| req_write | input | 1 | Request is a write (0 = read) |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_reg | input | 6 | Target register (dword) number |
| out_valid | output | 1 | One-cycle pulse marking a new outcome |
| out_kind | output | 2 | 0 type-0 cycle, 1 special cycle, 2 pass onward, 3 master abort |
| out_addr | output | 32 | Secondary-bus address for the cycle |
| out_ones | output | 1 | Read completes with all-ones data |

## Verification
The bench probes the device boundaries 15/16, 30 and 31, where an off-by-one comparison would turn a valid IDSEL into an abort or misplace the special-cycle device. It sets the compatibility flag on requests that would otherwise be claimed, including device 31 and an invalid device. A design that lets any other field outrank that flag would emit a configuration or special cycle. Chain-end aborts and mismatched bus numbers are exercised for both reads and writes, so that an all-ones flag raised on writes, or a pass that is never turned into an abort, is exposed. Back-to-back requests and idle gaps check that the valid pulse neither stretches nor drops and that the outputs hold.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    OC_CFG0    = 2'd0,
    OC_SPECIAL = 2'd1,
    OC_PASS    = 2'd2,
    OC_ABORT   = 2'd3
  } outcome_e;

endpackage

// File: rtl/cfgx_classify.sv
module cfgx_classify
  import cfgx_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int IDSEL_CNT = 16
) (
  input  logic             is_special,
  input  logic             compat,
  input  logic             chain_end,
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [DEV_W-1:0] dev,
  output outcome_e         outcome
);

  localparam logic [DEV_W-1:0] SPECIAL_DEV = '1;

  logic     bus_hit;
  logic     dev_mapped;
  logic     dev_special;
  outcome_e unclaimed;

  always_comb begin
    bus_hit     = (bus == sec_bus);
    dev_mapped  = (int'(dev) < IDSEL_CNT);
    dev_special = (dev == SPECIAL_DEV);
    unclaimed   = chain_end ? OC_ABORT : OC_PASS;
  end

  // Priority: compatibility and native special cycles are never claimed,
  // then foreign bus numbers, then device-number decode.
  always_comb begin
    if (compat || is_special) begin
      outcome = unclaimed;
    end else if (!bus_hit) begin
      outcome = unclaimed;
    end else if (dev_special) begin
      outcome = OC_SPECIAL;
    end else if (dev_mapped) begin
      outcome = OC_CFG0;
    end else begin
      outcome = OC_ABORT;
    end
  end

endmodule

// File: rtl/cfgx_idsel_enc.sv
module cfgx_idsel_enc #(
  parameter int DEV_W     = 5,
  parameter int IDSEL_CNT = 16
) (
  input  logic                 enable,
  input  logic [DEV_W-1:0]     dev,
  output logic [IDSEL_CNT-1:0] lines
);

  for (genvar g = 0; g < IDSEL_CNT; g++) begin : g_line
    assign lines[g] = enable && (dev == DEV_W'(g));
  end

endmodule

// File: rtl/cfgx_out_reg.sv
module cfgx_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
  import cfgx_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FUNC_W     = 3,
  parameter int REG_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int IDSEL_BASE = 16,
  parameter int IDSEL_CNT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  sec_bus_num,
  input  logic              chain_end,
  input  logic              req_valid,
  input  logic              req_special,
  input  logic              req_compat,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [REG_W-1:0]  req_reg,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ones
);

  localparam int REG_LSB  = 2;
  localparam int FUNC_LSB = REG_LSB + REG_W;
  localparam int PAY_W    = 2 + ADDR_W + 1;

  outcome_e              outcome;
  logic [IDSEL_CNT-1:0]  idsel;
  logic [ADDR_W-1:0]     addr_nxt;
  logic                  ones_nxt;
  logic [PAY_W-1:0]      pay_d;
  logic [PAY_W-1:0]      pay_q;
  logic                  valid_nxt;

  cfgx_classify #(
    .BUS_W     (BUS_W),
    .DEV_W     (DEV_W),
    .IDSEL_CNT (IDSEL_CNT)
  ) u_classify (
    .is_special (req_special),
    .compat     (req_compat),
    .chain_end  (chain_end),
    .bus        (req_bus),
    .sec_bus    (sec_bus_num),
    .dev        (req_dev),
    .outcome    (outcome)
  );

  cfgx_idsel_enc #(
    .DEV_W     (DEV_W),
    .IDSEL_CNT (IDSEL_CNT)
  ) u_idsel (
    .enable (outcome == OC_CFG0),
    .dev    (req_dev),
    .lines  (idsel)
  );

  always_comb begin
    addr_nxt = '0;
    if (outcome == OC_CFG0) begin
      addr_nxt[IDSEL_BASE +: IDSEL_CNT] = idsel;
      addr_nxt[FUNC_LSB +: FUNC_W]      = req_func;
      addr_nxt[REG_LSB +: REG_W]        = req_reg;
    end
    ones_nxt  = (outcome == OC_ABORT) && !req_write;
    pay_d     = {outcome, addr_nxt, ones_nxt};
    valid_nxt = req_valid;
  end

  cfgx_out_reg #(
    .W (PAY_W)
  ) u_pay_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (req_valid),
    .d     (pay_d),
    .q     (pay_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end

  assign out_kind = pay_q[PAY_W-1 -: 2];
  assign out_addr = pay_q[1 +: ADDR_W];
  assign out_ones = pay_q[0];

  // Assertions
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_kind) && $stable(out_addr) && $stable(out_ones)));
  a_r1_onehot_idsel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |-> $onehot(out_addr[IDSEL_BASE +: IDSEL_CNT]));
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[REG_LSB-1:0] == '0));
  a_r3_special_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1) |-> (out_addr == '0));
  a_r5_compat_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_compat) |=> (out_kind == 2'd2 || out_kind == 2'd3));
  a_r6_native_special_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_special) |=> (out_kind == 2'd2 || out_kind == 2'd3));
  a_r10_ones_only_abort: assert property (@(posedge clk) disable iff (!rst_n)
    out_ones |-> (out_kind == 2'd3));

endmodule

// File: tb/tb_cfgx_translator.sv
module tb_cfgx_translator;

  typedef struct packed {
    logic       special;
    logic       compat;
    logic       chain_end;
    logic       write;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regn;
    logic [1:0] exp_kind;
    logic       exp_ones;
  } vec_t;

  localparam int NV = 14;
  localparam logic [7:0] SEC = 8'h05;

  // Expected kinds: 0 type-0, 1 special, 2 pass, 3 abort
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 5'd0,  3'd0, 6'd0,  2'd0, 1'b0}, // R1 dev 0
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 5'd15, 3'd7, 6'd63, 2'd0, 1'b0}, // R1 R2 dev 15
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 5'd7,  3'd3, 6'd21, 2'd0, 1'b0}, // R2 mixed fields
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 5'd31, 3'd2, 6'd9,  2'd1, 1'b0}, // R3
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 5'd16, 3'd1, 6'd4,  2'd3, 1'b1}, // R4 read
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 5'd30, 3'd1, 6'd4,  2'd3, 1'b0}, // R4 write
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 5'd3,  3'd0, 6'd1,  2'd2, 1'b0}, // R5 pass
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 5'd3,  3'd0, 6'd1,  2'd3, 1'b1}, // R5 chain end
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 5'd31, 3'd0, 6'd0,  2'd2, 1'b0}, // R5 over dev 31
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 5'd31, 3'd0, 6'd0,  2'd2, 1'b0}, // R6 pass
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h05, 5'd2,  3'd0, 6'd0,  2'd3, 1'b0}, // R6 abort write
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 5'd2,  3'd1, 6'd3,  2'd2, 1'b0}, // R7 pass
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 5'd2,  3'd1, 6'd3,  2'd3, 1'b1}, // R7 abort read
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 5'd16, 3'd0, 6'd0,  2'd2, 1'b0}  // R5 over invalid dev
  };

  logic        clk;
  logic        rst_n;
  logic        chain_end;
  logic        req_valid;
  logic        req_special;
  logic        req_compat;
  logic        req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [5:0]  req_reg;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [31:0] out_addr;
  logic        out_ones;

  int applied;
  int errors;

  cfgx_translator dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_bus_num (SEC),
    .chain_end   (chain_end),
    .req_valid   (req_valid),
    .req_special (req_special),
    .req_compat  (req_compat),
    .req_write   (req_write),
    .req_bus     (req_bus),
    .req_dev     (req_dev),
    .req_func    (req_func),
    .req_reg     (req_reg),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_addr    (out_addr),
    .out_ones    (out_ones)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] model_addr(vec_t v);
    logic [31:0] a;
    a = 32'h0;
    if (v.exp_kind == 2'd0) begin
      a[16 + int'(v.dev)] = 1'b1;
      a[10:8] = v.func;
      a[7:2]  = v.regn;
    end
    return a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    req_special = v.special;
    req_compat  = v.compat;
    chain_end   = v.chain_end;
    req_write   = v.write;
    req_bus     = v.bus;
    req_dev     = v.dev;
    req_func    = v.func;
    req_reg     = v.regn;
  endtask

  task automatic check_out(string req, vec_t v);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " kind"},  32'(out_kind),  32'(v.exp_kind));
    check({req, " addr"},  out_addr,       model_addr(v));
    check({req, " ones"},  32'(out_ones),  32'(v.exp_ones));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    applied     = 0;
    errors      = 0;
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    drive(VEC[1]);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", 32'(out_valid), 32'd0);
    check("R9 kind",  32'(out_kind),  32'd0);
    check("R9 addr",  out_addr,       32'd0);
    check("R9 ones",  32'(out_ones),  32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_out($sformatf("vec%0d R1/R2/R3/R4/R5/R6/R7/R10", i), VEC[i]);
      drive(VEC[(i + 5) % NV]);
      @(negedge clk);
      // R8 pulse ends and outputs hold while idle
      check("R8 pulse single", 32'(out_valid), 32'd0);
      check("R8 hold kind",    32'(out_kind),  32'(VEC[i].exp_kind));
      check("R8 hold addr",    out_addr,       model_addr(VEC[i]));
    end

    // R8 back-to-back requests: one pulse per request, newest outcome
    @(negedge clk);
    drive(VEC[3]);
    req_valid = 1'b1;
    @(negedge clk);
    check_out("R8 b2b first R3", VEC[3]);
    drive(VEC[4]);
    @(negedge clk);
    req_valid = 1'b0;
    check_out("R8 b2b second R4", VEC[4]);
    @(negedge clk);
    check("R8 b2b end", 32'(out_valid), 32'd0);

    // R9 reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 re-reset kind", 32'(out_kind), 32'd0);
    check("R9 re-reset ones", 32'(out_ones), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule